// File: doc/BRIEF.md
# Multi-Channel Tone-Disable Interrupt Queue

This block watches two tone-disable status lines on each of 32 voice channels and tells a host about every change through one active-low interrupt line. Each rise or fall of an unmasked status line is an event. The block latches the event against its channel. A fixed-priority arbiter then moves each latched channel into a first-in first-out queue of channel numbers.

The host reads one queue entry per access to the queue address and learns which channel changed. It then reads that channel's status register to find the cause. The interrupt line goes high after every queue read. After a short hold-off it falls again while entries remain, so each entry gives the host its own falling edge. Software can block the interrupt line with a global mask bit, and can block either source of any channel with a per-channel mask bit.

Top module: `irq_event_fifo`

## Requirements
- R1: A rise or a fall on an unmasked status line `td_a[c]` or `td_b[c]` queues channel number c. A read of the queue address 0x01 returns it in bits 4:0, with bits 7:5 zero.
- R2: Queue entries are read out in the order their events were queued, oldest first, whatever their channel numbers.
- R3: When several channels change in the same cycle, every one is queued, lowest channel number first.
- R4: `irq_n` is low while the queue holds entries, no mask applies and no hold-off runs. The cycle after a queue read, `irq_n` is high.
- R5: After a queue read, `irq_n` stays high for at least 2 cycles. It then falls again if entries remain, which gives one low pulse per entry.
- R6: A read of the empty queue returns 8'hFF, with bit 7 as the empty flag, and removes nothing.
- R7: Bit 5 of the main control register (address 0x00) holds `irq_n` high. While it is set, events are still queued and stored entries are kept.
- R8: In the channel control register at 0x20+c, bit 3 masks source A and bit 4 masks source B. A change on a masked source is not queued.
- R9: The channel status register at 0x40+c shows the current state of source A in bit 0 and source B in bit 1.
- R10: The queue holds 64 entries and never overflows. An event that arrives while the queue is full stays latched and is queued once a read frees a slot.
- R11: Reset empties the queue, clears all masks and drives `irq_n` high. Control registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| td_a | input | 32 | Source A tone-disable status, one bit per channel |
| td_b | input | 32 | Source B tone-disable status, one bit per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at 0x01 pops the queue) |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The checker tests the interrupt line against the queue on every cycle. It checks that `irq_n` never sits low on an empty queue, that it rises after each queue read and holds for two cycles, and that it stays high under the global mask. It also checks that an empty read returns the empty code and that the fill level stays within the depth. The bench scenarios cover what a cycle-local property cannot see: the channel numbers and their age order, the lowest-first ordering of simultaneous events, the effect of the per-source masks, the status bits, and the holding of an event while the queue is full until a slot frees.

// File: rtl/irq_evt_pkg.sv
`timescale 1ns/1ps
// Package irq_evt_pkg: register map and bit positions shared by the
// interrupt queue modules and its checker.
package irq_evt_pkg;
    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned DATA_W     = 8;
    localparam logic [6:0]  ADR_MAIN   = 7'h00;
    localparam logic [6:0]  ADR_QUEUE  = 7'h01;
    localparam logic [1:0]  PAGE_CTL   = 2'b01;   // 0x20..0x3F
    localparam logic [1:0]  PAGE_STS   = 2'b10;   // 0x40..0x5F
    localparam int unsigned GMASK_BIT  = 5;
    localparam int unsigned MASK_A_BIT = 3;
    localparam int unsigned MASK_B_BIT = 4;
    localparam logic [7:0]  EMPTY_CODE = 8'hFF;
endpackage

// File: rtl/irq_evt_detect.sv
`timescale 1ns/1ps
// Module irq_evt_detect: finds changes on two status lines per channel,
// applies the per-source masks, latches each event per channel, and offers
// the lowest pending channel for queueing.
// Assumes the status inputs are already synchronous to clk.
module irq_evt_detect #(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned ID_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] td_a,
    input  logic [NUM_CH-1:0] td_b,
    input  logic [NUM_CH-1:0] mask_a,
    input  logic [NUM_CH-1:0] mask_b,
    input  logic              push_ready,
    output logic              push_valid,
    output logic [ID_W-1:0]   push_id,
    output logic [NUM_CH-1:0] sts_a,
    output logic [NUM_CH-1:0] sts_b
);
    logic [NUM_CH-1:0] pending_q;
    logic [NUM_CH-1:0] events;
    logic [NUM_CH-1:0] grant;

    // Event = unmasked change against the last sampled state.
    assign events = ((td_a ^ sts_a) & ~mask_a) | ((td_b ^ sts_b) & ~mask_b);

    // Fixed priority: the lowest pending channel wins.
    always_comb begin
        logic found;
        found   = 1'b0;
        grant   = '0;
        push_id = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pending_q[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                push_id  = ID_W'(i);
            end
        end
    end

    assign push_valid = |pending_q;

    // Sample status and keep pending events until they are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_a     <= '0;
            sts_b     <= '0;
            pending_q <= '0;
        end else begin
            sts_a     <= td_a;
            sts_b     <= td_b;
            pending_q <= (pending_q & ~(push_ready ? grant : '0)) | events;
        end
    end
endmodule

// File: rtl/irq_evt_queue.sv
`timescale 1ns/1ps
// Module irq_evt_queue: circular first-in first-out store of channel
// numbers. It refuses a push when full and ignores a pop when empty.
module irq_evt_queue #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned ID_W  = 5,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            empty,
    output logic            full,
    output logic [CNT_W-1:0] count
);
    logic [ID_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_id = mem[rd_ptr];

    // Storage write; the array itself needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_id;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/irq_evt_pulse.sv
`timescale 1ns/1ps
// Module irq_evt_pulse: drives the active-low interrupt. The line goes high
// on every queue read and stays high for a hold-off of HOLD_CYC cycles, so
// each remaining entry gives a separate falling edge.
module irq_evt_pulse #(
    parameter int unsigned HOLD_CYC = 2,
    localparam int unsigned HC_W = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pop_req,
    input  logic nonempty,
    input  logic gmask,
    output logic irq_n
);
    logic [HC_W-1:0] hold_q;

    // Hold-off counter and registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            irq_n  <= 1'b1;
        end else if (pop_req) begin
            hold_q <= HC_W'(HOLD_CYC);
            irq_n  <= 1'b1;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            irq_n  <= 1'b1;
        end else begin
            irq_n  <= !(nonempty && !gmask);
        end
    end
endmodule

// File: rtl/irq_event_fifo.sv
`timescale 1ns/1ps
// Module irq_event_fifo: top of the tone-disable interrupt queue. Holds the
// control registers, decodes register reads and writes, and connects event
// detection, queue and interrupt pulse logic.
// Assumes NUM_CH <= 32 so that a channel index fits the 5-bit register page.
module irq_event_fifo
    import irq_evt_pkg::*;
#(
    parameter int unsigned NUM_CH   = 32,
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned HOLD_CYC = 2,
    localparam int unsigned ID_W  = $clog2(NUM_CH),
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] td_a,
    input  logic [NUM_CH-1:0] td_b,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic              gmask_q;
    logic [NUM_CH-1:0] mask_a_q, mask_b_q;
    logic [NUM_CH-1:0] sts_a, sts_b;
    logic              push_valid, q_empty, q_full, pop_req;
    logic [ID_W-1:0]   push_id, head_id;
    logic [CNT_W-1:0]  q_count;
    logic [ID_W-1:0]   ch_idx;
    logic              ch_ok, sel_ctl, sel_sts;

    assign ch_idx  = reg_addr[ID_W-1:0];
    assign ch_ok   = ({27'd0, reg_addr[4:0]} < NUM_CH);
    assign sel_ctl = (reg_addr[6:5] == PAGE_CTL) && ch_ok;
    assign sel_sts = (reg_addr[6:5] == PAGE_STS) && ch_ok;
    assign pop_req = reg_rd && (reg_addr == ADR_QUEUE);

    // Control register writes: global mask and per-channel source masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask_q  <= 1'b0;
            mask_a_q <= '0;
            mask_b_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_MAIN) gmask_q <= reg_wdata[GMASK_BIT];
            if (sel_ctl) begin
                mask_a_q[ch_idx] <= reg_wdata[MASK_A_BIT];
                mask_b_q[ch_idx] <= reg_wdata[MASK_B_BIT];
            end
        end
    end

    // Read data multiplexer, combinational from the address.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_MAIN) begin
            reg_rdata[GMASK_BIT] = gmask_q;
        end else if (reg_addr == ADR_QUEUE) begin
            reg_rdata = q_empty ? EMPTY_CODE : DATA_W'(head_id);
        end else if (sel_ctl) begin
            reg_rdata[MASK_A_BIT] = mask_a_q[ch_idx];
            reg_rdata[MASK_B_BIT] = mask_b_q[ch_idx];
        end else if (sel_sts) begin
            reg_rdata[0] = sts_a[ch_idx];
            reg_rdata[1] = sts_b[ch_idx];
        end
    end

    irq_evt_detect #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .td_a(td_a), .td_b(td_b),
        .mask_a(mask_a_q), .mask_b(mask_b_q), .push_ready(!q_full),
        .push_valid(push_valid), .push_id(push_id),
        .sts_a(sts_a), .sts_b(sts_b)
    );

    irq_evt_queue #(.DEPTH(DEPTH), .ID_W(ID_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push_valid), .push_id(push_id),
        .pop(pop_req), .head_id(head_id), .empty(q_empty), .full(q_full),
        .count(q_count)
    );

    irq_evt_pulse #(.HOLD_CYC(HOLD_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .nonempty(!q_empty),
        .gmask(gmask_q), .irq_n(irq_n)
    );
endmodule

// File: rtl/irq_event_fifo_chk.sv
`timescale 1ns/1ps
// Module irq_event_fifo_chk: cycle-level properties of the interrupt line
// against the queue state, attached to irq_event_fifo by bind.
module irq_event_fifo_chk
    import irq_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_n,
    input logic              gmask_q,
    input logic [CNT_W-1:0]  q_count
);
    logic rd_q;
    assign rd_q = reg_rd && (reg_addr == ADR_QUEUE);

    assert_irq_high_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> irq_n);

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> ##1 irq_n);

    assert_irq_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (q_count != '0));

    assert_gmask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_q |=> irq_n);

    assert_empty_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0 && reg_addr == ADR_QUEUE) |-> (reg_rdata == EMPTY_CODE));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));
endmodule

bind irq_event_fifo irq_event_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .irq_n(irq_n), .gmask_q(gmask_q), .q_count(q_count)
);

// File: tb/test_irq_event_fifo.sv
`timescale 1ns/1ps
// Bench test_irq_event_fifo: sweeps every channel and source, then checks
// simultaneous, masked, globally masked and full-queue cases.
module test_irq_event_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] td_a = '0, td_b = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;
    int          checks = 0, failures = 0, cyc = 0;
    bit          done = 1'b0;

    irq_event_fifo i_irq_event_fifo (
        .clk(clk), .rst_n(rst_n), .td_a(td_a), .td_b(td_b),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Pops one entry; returns at the negedge after the popping edge.
    task automatic rd_queue(output logic [7:0] d);
        @(negedge clk);
        reg_addr = 7'h01; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_pop(input int exp, input string req);
        logic [7:0] d;
        rd_queue(d);
        check(d == 8'(exp), req, d, exp);
    endtask

    initial begin
        logic [7:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R11: reset state
        check(irq_n == 1'b1, "R11 irq after reset", irq_n, 1);
        rd_reg(7'h00, d);
        check(d == 8'h00, "R11 main ctl reset", d, 0);
        rd_reg(7'h20 + 7'd9, d);
        check(d == 8'h00, "R11 chan ctl reset", d, 0);
        // R6: empty read
        expect_pop(255, "R6 empty read");

        // R1/R4/R9: sweep every channel and both sources, rise then fall
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 32; c++) begin
                for (int lvl = 1; lvl >= 0; lvl--) begin
                    if (s == 0) td_a[c] = lvl[0]; else td_b[c] = lvl[0];
                    tick(6);
                    check(irq_n == 1'b0, "R4 irq low with entry", irq_n, 0);
                    rd_reg(7'h40 + 7'(c), d);
                    check(d == 8'(lvl << s), "R9 status bits", d, lvl << s);
                    expect_pop(c, "R1 channel number");
                    check(irq_n == 1'b1, "R4 irq high after read", irq_n, 1);
                    tick(4);
                    check(irq_n == 1'b1, "R4 irq high when empty", irq_n, 1);
                end
            end
        end

        // R2: age order, not channel order
        td_a[9] = 1'b1; tick(5);
        td_a[2] = 1'b1; tick(5);
        td_a[20] = 1'b1; tick(5);
        expect_pop(9, "R2 oldest first");
        expect_pop(2, "R2 oldest first");
        expect_pop(20, "R2 oldest first");
        td_a[9] = 1'b0; td_a[2] = 1'b0; td_a[20] = 1'b0;
        tick(10);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] v;
            rd_queue(v);
        end
        expect_pop(255, "R2 drained");

        // R3/R5: all channels at once, lowest first, one pulse per entry
        td_a = '1;
        tick(40);
        for (int i = 0; i < 32; i++) begin
            check(irq_n == 1'b0, "R5 pulse per entry", irq_n, 0);
            expect_pop(i, "R3 lowest channel first");
            check(irq_n == 1'b1, "R5 hold after read", irq_n, 1);
            tick(1);
            check(irq_n == 1'b1, "R5 hold second cycle", irq_n, 1);
            tick(3);
        end
        check(irq_n == 1'b1, "R5 no pulse when empty", irq_n, 1);
        td_a = '0;
        tick(40);
        for (int i = 0; i < 32; i++) expect_pop(i, "R3 release order");

        // R8: per-source masks
        wr_reg(7'h20 + 7'd3, 8'h08);
        rd_reg(7'h20 + 7'd3, d);
        check(d == 8'h08, "R11 chan ctl readback", d, 8);
        td_a[3] = 1'b1; tick(10);
        check(irq_n == 1'b1, "R8 masked A no irq", irq_n, 1);
        expect_pop(255, "R8 masked A not queued");
        td_b[3] = 1'b1; tick(6);
        expect_pop(3, "R8 unmasked B queued");
        wr_reg(7'h20 + 7'd7, 8'h10);
        td_b[7] = 1'b1; tick(10);
        expect_pop(255, "R8 masked B not queued");
        td_a[7] = 1'b1; tick(6);
        expect_pop(7, "R8 unmasked A queued");
        wr_reg(7'h20 + 7'd3, 8'h00);
        wr_reg(7'h20 + 7'd7, 8'h00);
        td_a[3] = 1'b0; td_b[3] = 1'b0; td_a[7] = 1'b0; td_b[7] = 1'b0;
        tick(10);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            rd_queue(v);
        end
        expect_pop(255, "R8 cleanup drained");

        // R7: global mask
        wr_reg(7'h00, 8'h20);
        rd_reg(7'h00, d);
        check(d == 8'h20, "R11 main ctl readback", d, 32);
        td_a[5] = 1'b1; tick(10);
        check(irq_n == 1'b1, "R7 mask holds irq high", irq_n, 1);
        wr_reg(7'h00, 8'h00);
        tick(3);
        check(irq_n == 1'b0, "R7 entry kept under mask", irq_n, 0);
        wr_reg(7'h00, 8'h20);
        tick(2);
        check(irq_n == 1'b1, "R7 mask set with entry", irq_n, 1);
        expect_pop(5, "R7 event queued under mask");
        wr_reg(7'h00, 8'h00);
        td_a[5] = 1'b0; tick(6);
        expect_pop(5, "R7 release queued");

        // R10: fill to 64, one more event waits for room
        td_a = '1; tick(40);
        td_a = '0; tick(40);
        td_b[0] = 1'b1; tick(10);
        for (int i = 0; i < 64; i++) expect_pop(i % 32, "R10 full queue order");
        expect_pop(0, "R10 held event queued after room");
        expect_pop(255, "R10 queue empty at end");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule